// File: doc/BRIEF.md
# Parallel Switch Debouncer with Column History

This block cleans up a bank of mechanical switch inputs that all share one timebase. Each raw input first crosses into the clock domain through a two-stage synchroniser. An internal prescaler produces a sample strobe. On every strobe, the whole input bank is captured in one parallel word and pushed onto a short stack of history words, so that every input is sampled at exactly the same instant.

For each input, the block reads the column of history bits at its bit position. A column that is all ones confirms the input high. A column that is all zeros confirms it low. A mixed column means the contact is still bouncing, and the last confirmed level is held.

A per-input mode mask decides how each confirmed level reaches the output. In momentary mode the output follows the confirmed level. In toggle mode the output flips once on each confirmed press.

Top module: `vdb_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `level_o`, `out_o` and `tick_o` are all 0.
- R2: `tick_o` is high for exactly one clock cycle. Consecutive pulses are exactly `TICK_CYCLES` cycles apart.
- R3: After an input changes and then stays steady, its confirmed level changes only after `DEPTH` sample strobes have captured the new value. With `DEPTH` = 4, three strobes are not enough. A change of `level_o` happens exactly two cycles after a `tick_o` pulse.
- R4: An input whose last `DEPTH` samples are all 1 is confirmed as 1. An input whose last `DEPTH` samples are all 0 is confirmed as 0.
- R5: An input whose stored samples are mixed keeps its previous confirmed level.
- R6: Each bit position is filtered on its own. Bits that keep bouncing have no effect on the confirmed level of steady bits.
- R7: Where `mode_mask` bit = 0 (momentary), that bit of `out_o` equals the same bit of `level_o` from one cycle earlier.
- R8: Where `mode_mask` bit = 1 (toggle), that bit of `out_o` shows a toggle state. The toggle state flips on each 0-to-1 change of the confirmed level and does not change on a 1-to-0 change. The toggle state is tracked in both modes and starts at 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | WIDTH | Asynchronous switch inputs |
| mode_mask | input | WIDTH | Per-bit mode: 1 = toggle, 0 = momentary |
| tick_o | output | 1 | One-cycle sample strobe |
| level_o | output | WIDTH | Confirmed (debounced) input levels |
| out_o | output | WIDTH | Presented output per mode mask |

## Verification
The bench settles every one of the 256 possible input words in turn. A column test that looked at fewer than all history words, or that swapped the ones and zeros confirmation, would produce a wrong level somewhere in that sweep.

A latency probe samples the level one strobe before and one strobe after the expected confirmation point. This catches a history that is one word too shallow or too deep.

Bits that alternate on every strobe, placed next to bits that settle, expose a design that releases a mixed column or lets neighbouring columns mix. A press and release sequence in toggle mode shows whether the toggle flips on releases or misses presses.

// File: rtl/vdb_pkg.sv
package vdb_pkg;
  typedef enum logic {
    MODE_MOMENTARY = 1'b0,
    MODE_TOGGLE    = 1'b1
  } vdb_mode_e;
endpackage

// File: rtl/vdb_sync.sv
module vdb_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/vdb_tick.sv
module vdb_tick #(
  parameter int TICK_CYCLES = 750000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/vdb_history.sv
module vdb_history #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic [WIDTH-1:0]       sample,
  output logic [WIDTH-1:0]       level,
  output logic [DEPTH*WIDTH-1:0] hist_flat
);
  logic [WIDTH-1:0] hist_q [DEPTH];

  // Word 0 takes the new capture; every older word moves up one place.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < DEPTH; d++) hist_q[d] <= '0;
    end else if (tick) begin
      hist_q[0] <= sample;
      for (int d = 1; d < DEPTH; d++) hist_q[d] <= hist_q[d-1];
    end
  end

  for (genvar d = 0; d < DEPTH; d++) begin : g_flat
    assign hist_flat[d*WIDTH +: WIDTH] = hist_q[d];
  end

  // Per-column agreement test and held level.
  for (genvar b = 0; b < WIDTH; b++) begin : g_col
    logic [DEPTH-1:0] col;
    logic             all_one, all_zero;

    for (genvar d = 0; d < DEPTH; d++) begin : g_bit
      assign col[d] = hist_q[d][b];
    end

    assign all_one  = &col;
    assign all_zero = ~|col;

    always_ff @(posedge clk) begin
      if (rst)           level[b] <= 1'b0;
      else if (all_one)  level[b] <= 1'b1;
      else if (all_zero) level[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/vdb_present.sv
module vdb_present
  import vdb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] mode_mask,
  output logic [WIDTH-1:0] out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic prev_q, tog_q;
    vdb_mode_e mode;

    assign mode = vdb_mode_e'(mode_mask[b]);

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        tog_q  <= 1'b0;
        out[b] <= 1'b0;
      end else begin
        prev_q <= level[b];
        if (level[b] && !prev_q) tog_q <= ~tog_q;
        out[b] <= (mode == MODE_TOGGLE) ? tog_q : level[b];
      end
    end
  end
endmodule

// File: rtl/vdb_top.sv
module vdb_top #(
  parameter int WIDTH       = 8,
  parameter int DEPTH       = 4,
  parameter int TICK_CYCLES = 750000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_in,
  input  logic [WIDTH-1:0] mode_mask,
  output logic             tick_o,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] out_o
);
  logic [WIDTH-1:0]       sync_w;
  logic [DEPTH*WIDTH-1:0] hist_flat;

  vdb_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_w)
  );

  vdb_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst(rst), .tick(tick_o)
  );

  vdb_history #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst(rst), .tick(tick_o), .sample(sync_w),
    .level(level_o), .hist_flat(hist_flat)
  );

  vdb_present #(.WIDTH(WIDTH)) u_pres (
    .clk(clk), .rst(rst), .level(level_o), .mode_mask(mode_mask), .out(out_o)
  );
endmodule

// File: rtl/vdb_chk.sv
module vdb_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tick_o,
  input logic [WIDTH-1:0]       mode_mask,
  input logic [WIDTH-1:0]       level_o,
  input logic [WIDTH-1:0]       out_o,
  input logic [DEPTH*WIDTH-1:0] hist_flat
);
  logic [WIDTH-1:0] ones_w, zeros_w, mixed_w;

  always_comb begin
    ones_w  = '1;
    zeros_w = '1;
    for (int d = 0; d < DEPTH; d++) begin
      ones_w  = ones_w  &  hist_flat[d*WIDTH +: WIDTH];
      zeros_w = zeros_w & ~hist_flat[d*WIDTH +: WIDTH];
    end
    mixed_w = ~(ones_w | zeros_w);
  end

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R3
  change_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (level_o != $past(level_o)) |-> $past(tick_o, 2));

  // R4
  confirm_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((level_o & $past(ones_w)) == $past(ones_w)) &&
              ((level_o & $past(zeros_w)) == '0)));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((level_o ^ $past(level_o)) & $past(mixed_w)) == '0));

  // R7
  momentary_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((out_o ^ $past(level_o)) & ~$past(mode_mask)) == '0));
endmodule

bind vdb_top vdb_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tick_o(tick_o), .mode_mask(mode_mask),
  .level_o(level_o), .out_o(out_o), .hist_flat(hist_flat)
);

// File: tb/tb_vdb_top.sv
module tb_vdb_top;
  localparam int W    = 8;
  localparam int D    = 4;
  localparam int TICK = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] raw_in = '0;
  logic [W-1:0] mode_mask = '0;
  logic         tick_o;
  logic [W-1:0] level_o, out_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [W-1:0] lvl_exp = '0;
  logic [W-1:0] tog_exp = '0;

  always #10 clk = ~clk;

  vdb_top #(.WIDTH(W), .DEPTH(D), .TICK_CYCLES(TICK)) dut (
    .clk(clk), .rst(rst), .raw_in(raw_in), .mode_mask(mode_mask),
    .tick_o(tick_o), .level_o(level_o), .out_o(out_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(negedge clk);
    while (!tick_o) @(negedge clk);
  endtask

  // Apply a steady word right after a strobe, let it confirm, update model.
  task automatic settle(input logic [W-1:0] v);
    wait_tick();
    raw_in = v;
    repeat (D + 1) wait_tick();
    repeat (4) @(negedge clk);
    tog_exp = tog_exp ^ (v & ~lvl_exp);
    lvl_exp = v;
  endtask

  function automatic logic [W-1:0] out_model();
    return (lvl_exp & ~mode_mask) | (tog_exp & mode_mask);
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1 level in reset", level_o, '0);
    check("R1 out in reset", out_o, '0);
    check("R1 tick in reset", {7'd0, tick_o}, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 level after release", level_o, '0);
    check("R1 out after release", out_o, '0);

    // R2: strobe spacing and width
    wait_tick();
    @(negedge clk);
    check("R2 strobe width", {7'd0, tick_o}, '0);
    begin
      int gap = 1;
      while (!tick_o) begin @(negedge clk); gap++; end
      check("R2 strobe spacing", W'(gap), W'(TICK));
    end

    // R4 and R7: every input word, momentary mode
    mode_mask = '0;
    for (int v = 0; v < 256; v++) begin
      settle(W'(v));
      check("R4 confirmed level", level_o, W'(v));
      check("R7 momentary out", out_o, W'(v));
    end

    // R3: confirmation latency of DEPTH strobes
    settle(8'h00);
    wait_tick();
    raw_in = 8'h5A;
    repeat (D - 1) wait_tick();
    repeat (3) @(negedge clk);
    check("R3 held after DEPTH-1 strobes", level_o, 8'h00);
    wait_tick();
    repeat (3) @(negedge clk);
    check("R3 confirmed after DEPTH strobes", level_o, 8'h5A);
    tog_exp = tog_exp ^ (8'h5A & ~lvl_exp);
    lvl_exp = 8'h5A;

    // R5 and R6: bits 4,5 bounce every strobe while the others settle
    settle(8'h0F);
    for (int k = 0; k < 2 * D + 2; k++) begin
      wait_tick();
      raw_in = (k % 2 == 1) ? 8'h3E : 8'h0E;
    end
    repeat (4) @(negedge clk);
    check("R5 bouncing bits held", level_o & 8'h30, 8'h00);
    check("R6 steady bits settled", level_o & 8'hCF, 8'h0E);
    settle(8'h0E);

    // R8: toggle mode on bits 3 and 7, others momentary
    mode_mask = 8'h88;
    @(negedge clk); @(negedge clk);
    check("R8 toggle view initial", out_o, out_model());
    settle(8'h00);
    check("R8 release no flip", out_o, out_model());
    settle(8'h88);
    check("R8 press flips", out_o, out_model());
    settle(8'h00);
    check("R8 release keeps", out_o, out_model());
    settle(8'h80);
    check("R8 single press bit7", out_o, out_model());
    settle(8'h08);
    check("R8 press bit3 release bit7", out_o, out_model());
    settle(8'hFF);
    check("R8 mixed modes all high", out_o, out_model());
    settle(8'h00);
    check("R8 mixed modes all low", out_o, out_model());

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule